// File: doc/BRIEF.md
# Address Rule Port Decoder

This block turns a transaction address into the index of the downstream port that should carry it. The lookup uses a rule table supplied at run time. Every rule names a target port and an address window given by a first address (inside the window) and a limit address (just outside it). More than one rule may name the same port, so a port can own several disjoint windows. The one table serves every upstream port at once.

Each upstream port has its own decoder lane with two private inputs: an enable that sends unmatched addresses to a fallback port, and the index of that fallback port. An address that hits no rule goes to the fallback port when the lane's enable is set. When the enable is clear, the lane selects a reserved index one above the last real port. The decode-error responder sits at that index. The error response itself is produced elsewhere.

The decode is purely combinational, so a new address or a new table gives new outputs in the same cycle. Each lane reports the selected index, a rule-hit flag, a decode-error flag and a flag for overlapping rules.

Top module: `addr_rule_decoder`

## Requirements
- R1: A rule matches an address when first <= address < limit: the first address is inside the window and the limit address is outside it.
- R2: When several rules match, the selected index is the port named by the lowest-numbered matching rule.
- R3: The overlap flag is 1 exactly when two or more rules match the same address, and it is never 1 without the hit flag.
- R4: When no rule matches and the lane's fallback enable is 1, the selected index equals that lane's fallback index, and both the hit flag and the error flag are 0.
- R5: When no rule matches and the fallback enable is 0, the selected index equals NUM_PORTS (4 at default parameters), the error flag is 1 and the hit flag is 0.
- R6: A matching rule takes precedence over an enabled fallback: the hit flag is 1 and the index comes from the rule.
- R7: Each upstream lane decodes its own address with its own fallback settings against the shared table, and its result does not depend on the inputs of any other lane.
- R8: A rule whose limit is less than or equal to its first address matches no address.
- R9: Several rules may name the same port, and an address inside any of those windows selects that port.
- R10: Outputs follow a change of the address or of the rule table within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | NUM_UP x ADDR_W | Address to decode, one per upstream lane |
| rule_port_i | input | NUM_RULES x IDX_W | Target port index of each rule |
| rule_first_i | input | NUM_RULES x ADDR_W | First address covered by each rule |
| rule_limit_i | input | NUM_RULES x ADDR_W | First address past the end of each rule |
| fb_en_i | input | NUM_UP | Fallback enable per lane |
| fb_port_i | input | NUM_UP x IDX_W | Fallback port index per lane |
| port_idx_o | output | NUM_UP x IDX_W | Selected downstream index per lane |
| hit_o | output | NUM_UP | A rule matched |
| decerr_o | output | NUM_UP | No match and fallback disabled |
| overlap_o | output | NUM_UP | Two or more rules matched |

## Verification
Two things can happen on the same decode: a priority choice among overlapping rules and the choice between a rule and the fallback. The bench provokes this by presenting an address that lies in two overlapping windows while the fallback is enabled. It expects the lower rule's port, the hit flag, and the overlap flag, and no fallback index. The two lanes are also driven in the same cycle with different table vectors and opposite fallback settings. Each lane is judged against its own expected row, which shows that the shared table causes no crosstalk.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    // Width of an index able to address n distinct targets, never below one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Where a lane's selected index came from.
    typedef enum logic [1:0] {
        SRC_RULE     = 2'd0,
        SRC_FALLBACK = 2'd1,
        SRC_DECERR   = 2'd2
    } sel_src_e;

endpackage

// File: rtl/rule_window_cmp.sv
module rule_window_cmp #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_RULES = 6
) (
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [NUM_RULES-1:0][ADDR_W-1:0]  first_i,
    input  logic [NUM_RULES-1:0][ADDR_W-1:0]  limit_i,
    output logic [NUM_RULES-1:0]              hit_vec_o
);

    // One half-open window comparator per rule; an inverted or empty
    // window can never satisfy both bounds.
    for (genvar r = 0; r < NUM_RULES; r++) begin : gen_win
        assign hit_vec_o[r] = (addr_i >= first_i[r]) && (addr_i < limit_i[r]);
    end

endmodule

// File: rtl/rule_prio_pick.sv
module rule_prio_pick #(
    parameter int unsigned NUM_RULES = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [NUM_RULES-1:0]             hit_vec_i,
    input  logic [NUM_RULES-1:0][IDX_W-1:0]  rule_port_i,
    output logic                             any_o,
    output logic                             multi_o,
    output logic [IDX_W-1:0]                 win_port_o
);

    always_comb begin
        win_port_o = '0;
        // Walk from the top so the lowest-numbered hit is written last.
        for (int r = NUM_RULES - 1; r >= 0; r--) begin
            if (hit_vec_i[r]) begin
                win_port_o = rule_port_i[r];
            end
        end
    end

    assign any_o   = |hit_vec_i;
    // Clearing the lowest set bit leaves something only when two or more are set.
    assign multi_o = |(hit_vec_i & (hit_vec_i - NUM_RULES'(1)));

    always_comb begin
        a_r3_overlap_needs_hit: assert (!multi_o || any_o)
            else $error("overlap flagged without any rule hit");
        a_r3_overlap_count: assert (multi_o == ($countones(hit_vec_i) > 1))
            else $error("overlap flag disagrees with hit count");
    end

endmodule

// File: rtl/lane_port_select.sv
module lane_port_select
    import addr_dec_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned IDX_W     = 3
) (
    input  logic             any_i,
    input  logic [IDX_W-1:0] win_port_i,
    input  logic             fb_en_i,
    input  logic [IDX_W-1:0] fb_port_i,
    output logic [IDX_W-1:0] port_idx_o,
    output logic             hit_o,
    output logic             decerr_o
);

    localparam logic [IDX_W-1:0] ERR_IDX = IDX_W'(NUM_PORTS);

    sel_src_e src;

    always_comb begin
        if (any_i) begin
            src = SRC_RULE;
        end else if (fb_en_i) begin
            src = SRC_FALLBACK;
        end else begin
            src = SRC_DECERR;
        end
    end

    always_comb begin
        unique case (src)
            SRC_RULE:     port_idx_o = win_port_i;
            SRC_FALLBACK: port_idx_o = fb_port_i;
            default:      port_idx_o = ERR_IDX;
        endcase
    end

    assign hit_o    = (src == SRC_RULE);
    assign decerr_o = (src == SRC_DECERR);

    always_comb begin
        a_r5_err_index: assert (!decerr_o || (port_idx_o == ERR_IDX))
            else $error("decode error without reserved index");
        a_r4_fallback_index: assert (hit_o || decerr_o || (port_idx_o == fb_port_i))
            else $error("fallback taken with wrong index");
        a_r6_hit_excludes_err: assert (!(hit_o && decerr_o))
            else $error("hit and decode error together");
        a_r6_rule_index: assert (!hit_o || (port_idx_o == win_port_i))
            else $error("rule hit with index not from rule");
    end

endmodule

// File: rtl/addr_rule_decoder.sv
module addr_rule_decoder
    import addr_dec_pkg::*;
#(
    parameter int unsigned NUM_UP    = 2,
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned NUM_RULES = 6,
    parameter int unsigned ADDR_W    = 32,
    localparam int unsigned IDX_W    = idx_bits(NUM_PORTS + 1)
) (
    input  logic [NUM_UP-1:0][ADDR_W-1:0]     addr_i,
    input  logic [NUM_RULES-1:0][IDX_W-1:0]   rule_port_i,
    input  logic [NUM_RULES-1:0][ADDR_W-1:0]  rule_first_i,
    input  logic [NUM_RULES-1:0][ADDR_W-1:0]  rule_limit_i,
    input  logic [NUM_UP-1:0]                 fb_en_i,
    input  logic [NUM_UP-1:0][IDX_W-1:0]      fb_port_i,
    output logic [NUM_UP-1:0][IDX_W-1:0]      port_idx_o,
    output logic [NUM_UP-1:0]                 hit_o,
    output logic [NUM_UP-1:0]                 decerr_o,
    output logic [NUM_UP-1:0]                 overlap_o
);

    // One independent lane per upstream port; the rule table is shared (R7).
    for (genvar u = 0; u < NUM_UP; u++) begin : gen_lane
        logic [NUM_RULES-1:0] hit_vec;
        logic                 any_hit;
        logic [IDX_W-1:0]     win_port;

        rule_window_cmp #(
            .ADDR_W    (ADDR_W),
            .NUM_RULES (NUM_RULES)
        ) cmp_i (
            .addr_i    (addr_i[u]),
            .first_i   (rule_first_i),
            .limit_i   (rule_limit_i),
            .hit_vec_o (hit_vec)
        );

        rule_prio_pick #(
            .NUM_RULES (NUM_RULES),
            .IDX_W     (IDX_W)
        ) pick_i (
            .hit_vec_i   (hit_vec),
            .rule_port_i (rule_port_i),
            .any_o       (any_hit),
            .multi_o     (overlap_o[u]),
            .win_port_o  (win_port)
        );

        lane_port_select #(
            .NUM_PORTS (NUM_PORTS),
            .IDX_W     (IDX_W)
        ) sel_i (
            .any_i      (any_hit),
            .win_port_i (win_port),
            .fb_en_i    (fb_en_i[u]),
            .fb_port_i  (fb_port_i[u]),
            .port_idx_o (port_idx_o[u]),
            .hit_o      (hit_o[u]),
            .decerr_o   (decerr_o[u])
        );

        always_comb begin
            a_r3_overlap_implies_hit: assert (!overlap_o[u] || hit_o[u])
                else $error("lane overlap without hit");
        end
    end

endmodule

// File: tb/addr_rule_decoder_tb_top.sv
module addr_rule_decoder_tb_top;

    localparam int unsigned NUM_UP    = 2;
    localparam int unsigned NUM_PORTS = 4;
    localparam int unsigned NUM_RULES = 6;
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned IDX_W     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NUM_UP-1:0][ADDR_W-1:0]     addr;
    logic [NUM_RULES-1:0][IDX_W-1:0]   rport;
    logic [NUM_RULES-1:0][ADDR_W-1:0]  rfirst;
    logic [NUM_RULES-1:0][ADDR_W-1:0]  rlimit;
    logic [NUM_UP-1:0]                 fb_en;
    logic [NUM_UP-1:0][IDX_W-1:0]      fb_port;
    logic [NUM_UP-1:0][IDX_W-1:0]      port_idx;
    logic [NUM_UP-1:0]                 hit;
    logic [NUM_UP-1:0]                 decerr;
    logic [NUM_UP-1:0]                 overlap;

    addr_rule_decoder #(
        .NUM_UP    (NUM_UP),
        .NUM_PORTS (NUM_PORTS),
        .NUM_RULES (NUM_RULES),
        .ADDR_W    (ADDR_W)
    ) dut_i (
        .addr_i       (addr),
        .rule_port_i  (rport),
        .rule_first_i (rfirst),
        .rule_limit_i (rlimit),
        .fb_en_i      (fb_en),
        .fb_port_i    (fb_port),
        .port_idx_o   (port_idx),
        .hit_o        (hit),
        .decerr_o     (decerr),
        .overlap_o    (overlap)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [31:0] a;
        logic        en;
        logic [2:0]  fb;
        logic [2:0]  idx;
        logic        hit;
        logic        err;
        logic        ovl;
    } vec_t;

    localparam int NV = 13;
    // Table: r0 port1 [1000,2000) r1 port2 [1800,3000) r2 port1 [4000,5000)
    //        r3 port3 [5000,6000) r4 port0 [9000,8000) r5 port2 [7000,7000)
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 1'b0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0}, // R1 first inclusive
        '{32'h0FFF, 1'b0, 3'd0, 3'd4, 1'b0, 1'b1, 1'b0}, // R5 below all
        '{32'h1FFF, 1'b0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b1}, // R2 R3 overlap
        '{32'h2000, 1'b0, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0}, // R1 limit exclusive
        '{32'h17FF, 1'b0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0}, // R1
        '{32'h4000, 1'b0, 3'd0, 3'd1, 1'b1, 1'b0, 1'b0}, // R9 second window
        '{32'h5000, 1'b0, 3'd0, 3'd3, 1'b1, 1'b0, 1'b0}, // R1 abutting windows
        '{32'h6000, 1'b1, 3'd2, 3'd2, 1'b0, 1'b0, 1'b0}, // R4 fallback
        '{32'h8800, 1'b0, 3'd0, 3'd4, 1'b0, 1'b1, 1'b0}, // R8 inverted window
        '{32'h7000, 1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0}, // R8 empty window
        '{32'h1800, 1'b1, 3'd3, 3'd1, 1'b1, 1'b0, 1'b1}, // R6 rule beats fallback
        '{32'h2FFF, 1'b0, 3'd0, 3'd2, 1'b1, 1'b0, 1'b0}, // R1 last in window
        '{32'h3000, 1'b0, 3'd0, 3'd4, 1'b0, 1'b1, 1'b0}  // R5 gap
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_rules();
        rport[0] = 3'd1; rfirst[0] = 32'h1000; rlimit[0] = 32'h2000;
        rport[1] = 3'd2; rfirst[1] = 32'h1800; rlimit[1] = 32'h3000;
        rport[2] = 3'd1; rfirst[2] = 32'h4000; rlimit[2] = 32'h5000;
        rport[3] = 3'd3; rfirst[3] = 32'h5000; rlimit[3] = 32'h6000;
        rport[4] = 3'd0; rfirst[4] = 32'h9000; rlimit[4] = 32'h8000;
        rport[5] = 3'd2; rfirst[5] = 32'h7000; rlimit[5] = 32'h7000;
    endtask

    task automatic check_lane(input int u, input vec_t v, input string tag);
        check({tag, " idx"},     int'(port_idx[u]), int'(v.idx));
        check({tag, " hit"},     int'(hit[u]),      int'(v.hit));
        check({tag, " decerr"},  int'(decerr[u]),   int'(v.err));
        check({tag, " overlap"}, int'(overlap[u]),  int'(v.ovl));
    endtask

    initial begin
        addr = '0; rport = '0; rfirst = '0; rlimit = '0; fb_en = '0; fb_port = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Cleared inputs: every window is empty, fallback off -> error index.
        for (int u = 0; u < NUM_UP; u++) begin
            check("R5 reset idx",    int'(port_idx[u]), NUM_PORTS);
            check("R5 reset decerr", int'(decerr[u]),   1);
            check("R8 reset hit",    int'(hit[u]),      0);
        end

        @(posedge clk);
        load_rules();
        // Lane 0 takes row k, lane 1 row k+1 in the same cycle (R7).
        for (int k = 0; k < NV; k++) begin
            @(posedge clk);
            addr[0] = VECS[k].a;          fb_en[0] = VECS[k].en;          fb_port[0] = VECS[k].fb;
            addr[1] = VECS[(k+1)%NV].a;   fb_en[1] = VECS[(k+1)%NV].en;   fb_port[1] = VECS[(k+1)%NV].fb;
            @(negedge clk);
            check_lane(0, VECS[k], $sformatf("R1/R2 lane0 row%0d", k));
            check_lane(1, VECS[(k+1)%NV], $sformatf("R7 lane1 row%0d", (k+1)%NV));
        end

        // Same address on both lanes, opposite fallback settings.
        @(posedge clk);
        addr[0] = 32'hA000; addr[1] = 32'hA000;
        fb_en[0] = 1'b1; fb_port[0] = 3'd3; fb_en[1] = 1'b0; fb_port[1] = 3'd3;
        @(negedge clk);
        check("R7 lane0 fallback", int'(port_idx[0]), 3);
        check("R7 lane1 error",    int'(port_idx[1]), 4);
        check("R4 lane0 no err",   int'(decerr[0]),   0);
        check("R5 lane1 err",      int'(decerr[1]),   1);

        // Table change with the address held: same-cycle effect (R10).
        @(posedge clk);
        addr[0] = 32'h5800; fb_en[0] = 1'b0;
        @(negedge clk);
        check("R10 before table change", int'(port_idx[0]), 3);
        @(posedge clk);
        rport[3] = 3'd0;
        @(negedge clk);
        check("R10 after table change", int'(port_idx[0]), 0);

        // Highest rule overlapping lower ones: lowest still wins (R2).
        @(posedge clk);
        rport[5] = 3'd3; rfirst[5] = 32'h0000; rlimit[5] = 32'hFFFF_FFFF;
        addr[0] = 32'h4800;
        @(negedge clk);
        check("R2 low rule wins idx", int'(port_idx[0]), 1);
        check("R3 overlap set",       int'(overlap[0]),  1);
        addr[0] = 32'h3000;
        #1;
        check("R2 only top rule idx", int'(port_idx[0]), 3);
        check("R3 single no overlap", int'(overlap[0]),  0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule